// File: doc/BRIEF.md
# Interrupt and Exception Priority Selector

This block decides which pending event a processor core services at an instruction boundary. Six event classes compete. Four are exception classes raised by the instruction itself: general faults, software trap instructions, debug traps on the current instruction, and debug faults on the next instruction. The other two are external interrupts: the non-maskable interrupt (NMI) and the maskable interrupt. In every cycle where the boundary strobe is high, the block looks at the eligible classes and reports exactly one of them as a one-hot vector with a valid strobe. The result is combinational within the boundary cycle. Vector lookup, stacking and running the handler belong to the surrounding core.

An exception class that loses arbitration is forgotten, because re-executing the instruction raises it again. A losing interrupt is not lost:

- The maskable request is a level. It stays visible for as long as the device holds it.
- An NMI request is edge-detected and held in an internal pending latch until it is chosen.

Once an NMI is chosen, further NMIs are blocked until the core reports a return from interrupt. One edge that arrives while NMIs are blocked is kept and serviced after that return.

The selection output has no back-pressure. The core takes the chosen class in the boundary cycle, so there is no ready signal. The outputs are plain strobes.

Top module: `event_prio_select`

## Requirements
- R1: When several classes are eligible, the one chosen follows this fixed order, highest first: general fault (sel_class bit 0), software trap (bit 1), debug trap for this instruction (bit 2), debug fault for the next instruction (bit 3), NMI (bit 4), maskable interrupt (bit 5).
- R2: sel_valid is high only in a cycle where at_boundary is high and at least one class is eligible. Whenever sel_valid is low, sel_class is all zero.
- R3: While sel_valid is high, exactly one bit of sel_class is set.
- R4: An exception request that loses a boundary is not remembered. A later boundary with no exception request selects nothing.
- R5: An NMI that loses a boundary to a higher class stays pending and is chosen at a later boundary.
- R6: After an NMI is selected, nmi_blocked is 1 from the next cycle on, and no NMI is selected until iret_seen has been high for a cycle. Lower classes are still served while NMIs are blocked.
- R7: Rising edges of nmi_req that arrive while NMIs are blocked are held as one pending NMI. That one NMI is served at the first boundary after the return, and no second NMI follows.
- R8: The maskable interrupt is eligible only while both intr_req and intr_enable are 1, and it is not latched. A request that is withdrawn before the flag is set is never served.
- R9: nmi_req is edge-sensitive. Holding it high after it has been served yields no further selection.
- R10: After reset, no NMI is pending and nmi_blocked is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| at_boundary | input | 1 | High in the cycle where an instruction boundary is evaluated |
| fault_req | input | 1 | Non-debug fault raised by the current instruction |
| swtrap_req | input | 1 | Software trap instruction request |
| dbg_trap_req | input | 1 | Debug trap for the current instruction |
| dbg_fault_req | input | 1 | Debug fault for the next instruction |
| nmi_req | input | 1 | Non-maskable interrupt line (edge-detected) |
| intr_req | input | 1 | Maskable interrupt line (level) |
| intr_enable | input | 1 | Interrupt-enable flag |
| iret_seen | input | 1 | Return from interrupt executed |
| sel_valid | output | 1 | A class is selected this cycle |
| sel_class | output | 6 | One-hot selected class |
| nmi_blocked | output | 1 | NMIs are held off until the next return |

## Verification
The bench walks the priority ladder one class at a time and checks each rung of the fixed order. A wrong order would hand a boundary to a lower class. It checks that a beaten exception does not come back at the next boundary; a design that stored exceptions would select a stale fault. It sends an NMI that loses to a fault, holds the NMI line high after service, and sends two edges while blocked. A design that forgets pending NMIs, treats the line as a level, or counts edges would show a missing or extra NMI selection. It also withdraws a maskable request before setting the enable flag, which a design that latched the request would serve anyway.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int unsigned NUM_CLASSES = 6;

  // Bit positions of the one-hot class vector; lower index wins arbitration.
  localparam int unsigned IDX_FAULT     = 0;
  localparam int unsigned IDX_SWTRAP    = 1;
  localparam int unsigned IDX_DBG_TRAP  = 2;
  localparam int unsigned IDX_DBG_FAULT = 3;
  localparam int unsigned IDX_NMI       = 4;
  localparam int unsigned IDX_INTR      = 5;

  typedef logic [NUM_CLASSES-1:0] class_vec_t;
endpackage

// File: rtl/evsel_prio_pick.sv
// Fixed-priority one-hot picker: index 0 has the highest priority.
module evsel_prio_pick #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  // above[g] is high when some request of higher priority than g is present.
  logic [N-1:0] above;

  assign above[0] = 1'b0;

  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_chain
      assign above[g] = above[g-1] | req[g-1];
    end
    for (g = 0; g < N; g++) begin : g_grant
      assign grant[g] = req[g] & ~above[g];
    end
  endgenerate

  assign any = |req;
endmodule

// File: rtl/evsel_nmi_track.sv
// NMI edge detection, pending latch and blocking state.
module evsel_nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic taken,
  input  logic iret_seen,
  output logic eligible,
  output logic blocked
);
  logic nmi_q;
  logic pend_q;
  logic rise;

  assign rise = nmi_req & ~nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q   <= 1'b0;
      pend_q  <= 1'b0;
      blocked <= 1'b0;
    end else begin
      nmi_q <= nmi_req;

      // A fresh edge always sets the latch; selection consumes the old one.
      pend_q <= rise | (pend_q & ~taken);

      // Entry to the handler wins over a return seen in the same cycle.
      if (taken) begin
        blocked <= 1'b1;
      end else if (iret_seen) begin
        blocked <= 1'b0;
      end
    end
  end

  assign eligible = pend_q & ~blocked;
endmodule

// File: rtl/event_prio_select.sv
module event_prio_select
  import evsel_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   at_boundary,
  input  logic                   fault_req,
  input  logic                   swtrap_req,
  input  logic                   dbg_trap_req,
  input  logic                   dbg_fault_req,
  input  logic                   nmi_req,
  input  logic                   intr_req,
  input  logic                   intr_enable,
  input  logic                   iret_seen,
  output logic                   sel_valid,
  output logic [NUM_CLASSES-1:0] sel_class,
  output logic                   nmi_blocked
);
  class_vec_t eligible;
  class_vec_t grant;
  logic       any_eligible;
  logic       nmi_ok;
  logic       nmi_taken;

  evsel_nmi_track i_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_req   (nmi_req),
    .taken     (nmi_taken),
    .iret_seen (iret_seen),
    .eligible  (nmi_ok),
    .blocked   (nmi_blocked)
  );

  always_comb begin
    eligible                = '0;
    eligible[IDX_FAULT]     = fault_req;
    eligible[IDX_SWTRAP]    = swtrap_req;
    eligible[IDX_DBG_TRAP]  = dbg_trap_req;
    eligible[IDX_DBG_FAULT] = dbg_fault_req;
    eligible[IDX_NMI]       = nmi_ok;
    eligible[IDX_INTR]      = intr_req & intr_enable;
  end

  evsel_prio_pick #(.N(NUM_CLASSES)) i_pick (
    .req   (eligible),
    .grant (grant),
    .any   (any_eligible)
  );

  assign sel_valid = at_boundary & any_eligible;
  assign sel_class = sel_valid ? grant : '0;
  assign nmi_taken = sel_valid & grant[IDX_NMI];
endmodule

// File: rtl/evsel_checker.sv
module evsel_checker
  import evsel_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   at_boundary,
  input logic                   fault_req,
  input logic                   intr_enable,
  input logic                   iret_seen,
  input logic                   sel_valid,
  input logic [NUM_CLASSES-1:0] sel_class,
  input logic                   nmi_blocked
);
  p_valid_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> at_boundary);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_class == '0));

  p_single_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ($countones(sel_class) == 1));

  p_fault_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && fault_req) |-> sel_class[IDX_FAULT]);

  p_block_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_class[IDX_NMI]) |=> nmi_blocked);

  p_no_nmi_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blocked |-> !sel_class[IDX_NMI]);

  p_block_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_blocked && !iret_seen) |=> nmi_blocked);

  p_unblock_on_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_blocked && iret_seen) |=> !nmi_blocked);

  p_masked_intr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_enable |-> !sel_class[IDX_INTR]);
endmodule

bind event_prio_select evsel_checker i_evsel_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .at_boundary (at_boundary),
  .fault_req   (fault_req),
  .intr_enable (intr_enable),
  .iret_seen   (iret_seen),
  .sel_valid   (sel_valid),
  .sel_class   (sel_class),
  .nmi_blocked (nmi_blocked)
);

// File: tb/test_event_prio_select.sv
module test_event_prio_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       at_boundary = 1'b0;
  logic       fault_req = 1'b0;
  logic       swtrap_req = 1'b0;
  logic       dbg_trap_req = 1'b0;
  logic       dbg_fault_req = 1'b0;
  logic       nmi_req = 1'b0;
  logic       intr_req = 1'b0;
  logic       intr_enable = 1'b0;
  logic       iret_seen = 1'b0;
  logic       sel_valid;
  logic [5:0] sel_class;
  logic       nmi_blocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       v;
    logic [5:0] c;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Class bit positions used by the checks (R1).
  localparam logic [5:0] C_FAULT = 6'b000001;
  localparam logic [5:0] C_SWTR  = 6'b000010;
  localparam logic [5:0] C_DTRP  = 6'b000100;
  localparam logic [5:0] C_DFLT  = 6'b001000;
  localparam logic [5:0] C_NMI   = 6'b010000;
  localparam logic [5:0] C_INTR  = 6'b100000;
  localparam logic [5:0] C_NONE  = 6'b000000;

  always #4 clk = ~clk;

  event_prio_select i_event_prio_select (
    .clk           (clk),
    .rst_n         (rst_n),
    .at_boundary   (at_boundary),
    .fault_req     (fault_req),
    .swtrap_req    (swtrap_req),
    .dbg_trap_req  (dbg_trap_req),
    .dbg_fault_req (dbg_fault_req),
    .nmi_req       (nmi_req),
    .intr_req      (intr_req),
    .intr_enable   (intr_enable),
    .iret_seen     (iret_seen),
    .sel_valid     (sel_valid),
    .sel_class     (sel_class),
    .nmi_blocked   (nmi_blocked)
  );

  // Monitor: pops the scoreboard at boundaries, checks idleness elsewhere.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (at_boundary) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty: valid=%b class=%b expected an entry", sel_valid, sel_class);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (sel_valid !== e.v || sel_class !== e.c) begin
            errors++;
            $display("FAIL %s: valid=%b class=%b expected valid=%b class=%b",
                     e.tag, sel_valid, sel_class, e.v, e.c);
          end
        end
      end else begin
        checks++;
        if (sel_valid !== 1'b0 || sel_class !== C_NONE) begin
          errors++;
          $display("FAIL R2 no boundary: valid=%b class=%b expected valid=0 class=000000",
                   sel_valid, sel_class);
        end
      end
    end
  end

  // Driver: one cycle per call. exp_blk < 0 skips the blocking-state check.
  task automatic step(input logic b, input logic f, input logic s, input logic dt,
                      input logic df, input logic n, input logic ir, input logic ie,
                      input logic ret, input logic [5:0] exp_cls, input int exp_blk,
                      input string tag);
    @(posedge clk);
    #1;
    at_boundary   = b;
    fault_req     = f;
    swtrap_req    = s;
    dbg_trap_req  = dt;
    dbg_fault_req = df;
    nmi_req       = n;
    intr_req      = ir;
    intr_enable   = ie;
    iret_seen     = ret;
    if (b) begin
      exp_t e;
      e.v   = (exp_cls != C_NONE);
      e.c   = exp_cls;
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    #1;
    if (exp_blk >= 0) begin
      checks++;
      if (nmi_blocked !== exp_blk[0]) begin
        errors++;
        $display("FAIL %s nmi_blocked: actual=%b expected=%0d", tag, nmi_blocked, exp_blk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    step(1,0,0,0,0,0,0,0,0, C_NONE, 0, "R10 reset idle");

    // R1: walk the priority ladder
    step(1,1,1,1,1,0,1,1,0, C_FAULT, 0, "R1 fault over all");
    step(1,0,1,1,1,0,1,1,0, C_SWTR,  0, "R1 swtrap over debug");
    step(1,0,0,1,1,0,1,1,0, C_DTRP,  0, "R1 dbg trap over dbg fault");
    step(1,0,0,0,1,0,1,1,0, C_DFLT,  0, "R1 dbg fault over intr");
    step(1,0,0,0,0,0,1,1,0, C_INTR,  0, "R1 intr alone");

    // R2: requests without a boundary produce nothing
    step(0,1,1,0,0,0,1,1,0, C_NONE, 0, "R2 no boundary");

    // R8: mask, and no latching of the level
    step(1,0,0,0,0,0,1,0,0, C_NONE, 0, "R8 intr masked");
    step(1,0,0,0,0,0,0,1,0, C_NONE, 0, "R8 intr withdrawn then enabled");

    // R4: losing exception dropped
    step(1,1,0,1,0,0,0,0,0, C_FAULT, 0, "R4 fault beats dbg trap");
    step(1,0,0,0,0,0,0,0,0, C_NONE,  0, "R4 dbg trap not remembered");

    // R5, R9: NMI loses to a fault, then is served once
    step(0,0,0,0,0,1,0,0,0, C_NONE,  0, "R5 nmi edge");
    step(1,1,0,0,0,1,0,0,0, C_FAULT, 0, "R5 fault beats pending nmi");
    step(1,0,0,0,0,1,1,1,0, C_NMI,   0, "R5 pending nmi beats intr");
    step(1,0,0,0,0,1,0,0,0, C_NONE,  1, "R9 held nmi level not reserved");
    step(0,0,0,0,0,0,0,0,1, C_NONE,  1, "R6 return");
    step(1,0,0,0,0,0,0,0,0, C_NONE,  0, "R9 nothing after return");

    // R6, R7: blocking and single latched edge
    step(1,0,0,0,0,1,1,1,0, C_INTR,  0, "R6 edge not yet pending");
    step(1,0,0,0,0,0,0,0,0, C_NMI,   0, "R6 nmi served");
    step(1,0,0,0,0,0,1,1,0, C_INTR,  1, "R6 intr served while blocked");
    step(0,0,0,0,0,1,0,0,0, C_NONE,  1, "R7 first edge");
    step(0,0,0,0,0,0,0,0,0, C_NONE,  1, "R7 gap");
    step(0,0,0,0,0,1,0,0,0, C_NONE,  1, "R7 second edge");
    step(1,0,0,0,0,0,0,0,0, C_NONE,  1, "R6 blocked nmi held off");
    step(0,0,0,0,0,0,0,0,1, C_NONE,  1, "R7 return");
    step(1,0,0,0,0,0,0,0,0, C_NMI,   0, "R7 latched nmi after return");
    step(0,0,0,0,0,0,0,0,1, C_NONE,  1, "R7 second return");
    step(1,0,0,0,0,0,0,0,0, C_NONE,  0, "R7 edges merged into one");

    // R3 via mixed pattern: debug fault with nmi pending
    step(0,0,0,0,0,1,0,0,0, C_NONE,  0, "R3 nmi edge");
    step(1,0,0,0,1,0,1,1,0, C_DFLT,  0, "R3 single class dbg fault");
    step(1,0,0,0,0,0,1,1,0, C_NMI,   0, "R3 single class nmi");

    step(0,0,0,0,0,0,0,0,0, C_NONE, -1, "end");
    if (!done) begin
      done = 1'b1;
      if (sb.size() != 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard leftover: actual=%0d expected=0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule